// File: doc/BRIEF.md
# Prioritized interrupt distributor

This block gathers a set of level-sensitive interrupt request lines, each known by its index (its ID), and decides which one, if any, is offered to a single processor. Software gives each line an enable bit and an 8-bit urgency value through a small register port. Software also sets a processor threshold. Any line seen high for one clock is latched as waiting, whether or not it is enabled. Among the waiting lines that are enabled and not already being serviced, the most urgent one is chosen. When two lines have the same urgency, the lower ID is chosen.

The single request output rises when the chosen line is strictly more urgent than the threshold. While handlers are running, the threshold in force is also bounded by the most urgent running handler, so nested handling happens only for strictly more urgent work. The processor claims the chosen line through the acknowledge port, which returns its ID and marks it as in service. When no line qualifies, the acknowledge port returns an all-ones spurious code. An end-of-service write with the ID releases the line. Lines that lose the choice stay waiting and are offered later in urgency order.

Top module: `irq_distributor`

## Requirements
- R1: After reset every enable bit is 0, the threshold is 8'h00, every urgency value is 8'h00, `irq` is low and `ack_id` reads the spurious code (all ones, 31 at 16 sources).
- R2: Register map on `cfg_addr`: address 0 holds the threshold in data bits [7:0], address 1 holds enable bit i for source i in data bit i, and address 2+i holds the urgency of source i in bits [7:0]. `cfg_rdata` combinationally returns the stored value, with unused bits 0. A write to any other address changes nothing, and such an address reads 0.
- R3: A source line high at a clock edge makes that source waiting. It stays waiting after the line drops, even while disabled, until it is acknowledged.
- R4: The chosen source is the waiting, enabled, not-in-service source with the numerically lowest urgency value. Ties go to the lower ID.
- R5: `irq` is high exactly when a chosen source exists and its urgency value is strictly below the effective threshold. With no source in service, the effective threshold is the programmed threshold. Otherwise it is the smaller of the programmed threshold and the lowest urgency value among sources in service.
- R6: With `ack_req` high in a cycle where `irq` is high, `ack_id` shows the chosen ID in that cycle. From the next cycle that source is in service and no longer waiting, unless its line was high at that edge, in which case it is waiting again.
- R7: With `ack_req` high while `irq` is low, `ack_id` is all ones and no state changes.
- R8: `eoi_valid` with the ID of a source in service ends its service from the next cycle. An end-of-service write for a source not in service, or for an ID of N_SRC or above, has no effect.
- R9: A source in service is never chosen again until its service ends. Only a source strictly more urgent than every running one can raise `irq`.
- R10: Sources that lose the choice stay waiting and are offered in turn, by urgency and then ID, as earlier ones are claimed and released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_lines | input | N_SRC (16) | Level request line per source, synchronous to clk |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W (5) | Register address for read and write |
| cfg_wdata | input | DATA_W (16) | Register write data |
| cfg_rdata | output | DATA_W (16) | Register read data for cfg_addr |
| ack_req | input | 1 | Acknowledge strobe: claim the chosen source |
| ack_id | output | ID_W (5) | Chosen ID, or all ones when nothing qualifies |
| eoi_valid | input | 1 | End-of-service strobe |
| eoi_id | input | ID_W (5) | ID whose service ends |
| irq | output | 1 | Request to the processor |

## Verification
Directed sequences first use three sources with distinct and tied urgency values. This separates selection by value from selection by ID. Nesting is probed with a running handler and a second request of equal or greater urgency, which tells the strict compare from a non-strict one. The threshold is set at and one above a waiting source's urgency. An end-of-service ID whose low bits alias a running source checks the range test. A line held high through its own acknowledge checks re-latching. A long random phase then mixes sparse line pulses, tied urgency values, threshold changes, spurious and valid claims, and releases of running, idle and out-of-range IDs against a behavioural model.

// File: rtl/irqd_pkg.sv
// Shared definitions for the interrupt distributor.
// Assumes: urgency is 8 bits wide, lower value means more urgent.
package irqd_pkg;
    localparam int PRIO_W = 8;
    typedef logic [PRIO_W-1:0] prio_t;

    // Register addresses; priority registers follow the base in source order.
    localparam int REG_MASK      = 0;
    localparam int REG_ENABLE    = 1;
    localparam int REG_PRIO_BASE = 2;

    // Returns the more urgent (numerically lower) of two urgency values.
    function automatic prio_t prio_min(input prio_t a, input prio_t b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/irqd_pick.sv
// Tournament tree that finds the most urgent candidate among N_SRC sources.
// Ties resolve toward the lower index, because the left subtree always holds
// the lower indices. With no candidate, found is 0 and best is all ones.
// Assumes: N_SRC >= 2; purely combinational.
module irqd_pick
    import irqd_pkg::*;
#(
    parameter int N_SRC = 16,
    localparam int IDX_W  = $clog2(N_SRC),
    localparam int LEAVES = 1 << $clog2(N_SRC),
    localparam int NODES  = 2 * LEAVES - 1
) (
    input  logic [N_SRC-1:0]  cand,
    input  prio_t [N_SRC-1:0] prio,
    output logic              found,
    output logic [IDX_W-1:0]  idx,
    output prio_t             best
);
    logic              node_v [NODES];
    prio_t             node_p [NODES];
    logic [IDX_W-1:0]  node_i [NODES];

    // Leaves: real sources load their candidate state, padding leaves stay empty.
    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < N_SRC) begin : g_real
            assign node_v[LEAVES-1+i] = cand[i];
            assign node_p[LEAVES-1+i] = cand[i] ? prio[i] : '1;
            assign node_i[LEAVES-1+i] = IDX_W'(i);
        end else begin : g_pad
            assign node_v[LEAVES-1+i] = 1'b0;
            assign node_p[LEAVES-1+i] = '1;
            assign node_i[LEAVES-1+i] = '0;
        end
    end

    // Inner nodes: keep the left child unless the right one is strictly better.
    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
        logic take_left;
        assign take_left = node_v[2*k+1] &&
                           (!node_v[2*k+2] || (node_p[2*k+1] <= node_p[2*k+2]));
        assign node_v[k] = node_v[2*k+1] | node_v[2*k+2];
        assign node_p[k] = take_left ? node_p[2*k+1] : node_p[2*k+2];
        assign node_i[k] = take_left ? node_i[2*k+1] : node_i[2*k+2];
    end

    assign found = node_v[0];
    assign idx   = node_i[0];
    assign best  = node_p[0];
endmodule

// File: rtl/irqd_cfg_regs.sv
// Software-visible configuration: threshold, enable vector and one urgency
// register per source, with a combinational read mux.
// Assumes: DATA_W >= N_SRC and DATA_W >= PRIO_W; unmapped addresses are inert.
module irqd_cfg_regs
    import irqd_pkg::*;
#(
    parameter int N_SRC  = 16,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output prio_t             cpu_mask,
    output logic [N_SRC-1:0]  src_enable,
    output prio_t [N_SRC-1:0] src_prio
);
    logic hit_mask, hit_enable;

    assign hit_mask   = (addr == ADDR_W'(REG_MASK));
    assign hit_enable = (addr == ADDR_W'(REG_ENABLE));

    // Threshold register: reset to 0 so nothing can be issued.
    always_ff @(posedge clk) begin
        if (!rst_n)               cpu_mask <= '0;
        else if (we && hit_mask)  cpu_mask <= wdata[PRIO_W-1:0];
    end

    // Enable vector: reset with every source disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                 src_enable <= '0;
        else if (we && hit_enable)  src_enable <= wdata[N_SRC-1:0];
    end

    // One urgency register per source.
    for (genvar i = 0; i < N_SRC; i++) begin : g_prio
        logic  hit;
        prio_t prio_q;
        assign hit = (addr == ADDR_W'(REG_PRIO_BASE + i));
        // Holds the urgency of source i.
        always_ff @(posedge clk) begin
            if (!rst_n)         prio_q <= '0;
            else if (we && hit) prio_q <= wdata[PRIO_W-1:0];
        end
        assign src_prio[i] = prio_q;
    end

    // Read mux: returns the addressed register, zero for unmapped addresses.
    always_comb begin
        rdata = '0;
        if (hit_mask)   rdata[PRIO_W-1:0] = cpu_mask;
        if (hit_enable) rdata[N_SRC-1:0]  = src_enable;
        for (int i = 0; i < N_SRC; i++) begin
            if (addr == ADDR_W'(REG_PRIO_BASE + i)) rdata[PRIO_W-1:0] = src_prio[i];
        end
    end
endmodule

// File: rtl/irqd_state.sv
// Per-source waiting and in-service flags.
// Waiting is sticky: set by a high line, cleared only by a claim. A line that
// is high in the claim cycle sets it again. In-service is set by a claim and
// cleared by a release.
// Assumes: take_fire only names a source that is not in service.
module irqd_state #(
    parameter int N_SRC = 16,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_lines,
    input  logic             take_fire,
    input  logic [IDX_W-1:0] take_idx,
    input  logic             done_fire,
    input  logic [IDX_W-1:0] done_idx,
    output logic [N_SRC-1:0] pend,
    output logic [N_SRC-1:0] act
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic take_me, done_me, pend_q, act_q;
        assign take_me = take_fire && (take_idx == IDX_W'(i));
        assign done_me = done_fire && (done_idx == IDX_W'(i));

        // Waiting flag: latch the line, drop on claim.
        always_ff @(posedge clk) begin
            if (!rst_n) pend_q <= 1'b0;
            else        pend_q <= (pend_q & ~take_me) | src_lines[i];
        end

        // In-service flag: set on claim, clear on release.
        always_ff @(posedge clk) begin
            if (!rst_n)       act_q <= 1'b0;
            else if (take_me) act_q <= 1'b1;
            else if (done_me) act_q <= 1'b0;
        end

        assign pend[i] = pend_q;
        assign act[i]  = act_q;
    end
endmodule

// File: rtl/irq_distributor.sv
// Prioritized interrupt distributor top.
// Chooses the most urgent waiting, enabled, idle source. It raises irq when
// that source beats the effective threshold, which is the smaller of the
// programmed threshold and the most urgent running handler. Claims and
// releases go through ack_* and eoi_*.
// Assumes: all inputs are synchronous to clk; N_SRC >= 2.
module irq_distributor
    import irqd_pkg::*;
#(
    parameter int N_SRC = 16,
    localparam int IDX_W  = $clog2(N_SRC),
    localparam int ID_W   = $clog2(N_SRC + 1),
    localparam int ADDR_W = $clog2(N_SRC + 2),
    localparam int DATA_W = (N_SRC > PRIO_W) ? N_SRC : PRIO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_lines,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              ack_req,
    output logic [ID_W-1:0]   ack_id,
    input  logic              eoi_valid,
    input  logic [ID_W-1:0]   eoi_id,
    output logic              irq
);
    prio_t              cpu_mask;
    logic [N_SRC-1:0]   src_enable;
    prio_t [N_SRC-1:0]  src_prio;
    logic [N_SRC-1:0]   pend, act, cand;
    logic               sel_found, run_found;
    logic [IDX_W-1:0]   sel_idx, run_idx;
    prio_t              sel_prio, run_prio, eff_thr;
    logic               ack_fire, eoi_fire;

    irqd_cfg_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .rdata      (cfg_rdata),
        .cpu_mask   (cpu_mask),
        .src_enable (src_enable),
        .src_prio   (src_prio)
    );

    irqd_state #(.N_SRC(N_SRC)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_lines (irq_lines),
        .take_fire (ack_fire),
        .take_idx  (sel_idx),
        .done_fire (eoi_fire),
        .done_idx  (eoi_id[IDX_W-1:0]),
        .pend      (pend),
        .act       (act)
    );

    // Candidates: waiting, enabled and not already in service.
    assign cand = pend & src_enable & ~act;

    irqd_pick #(.N_SRC(N_SRC)) u_pick_sel (
        .cand  (cand),
        .prio  (src_prio),
        .found (sel_found),
        .idx   (sel_idx),
        .best  (sel_prio)
    );

    irqd_pick #(.N_SRC(N_SRC)) u_pick_run (
        .cand  (act),
        .prio  (src_prio),
        .found (run_found),
        .idx   (run_idx),
        .best  (run_prio)
    );

    // Effective threshold: a running handler tightens the programmed one.
    assign eff_thr = run_found ? prio_min(cpu_mask, run_prio) : cpu_mask;

    // Request and claim decode.
    assign irq      = sel_found && (sel_prio < eff_thr);
    assign ack_fire = ack_req && irq;
    assign ack_id   = irq ? ID_W'(sel_idx) : '1;

    // Release is honoured only for an ID inside the source range.
    assign eoi_fire = eoi_valid && (eoi_id <= ID_W'(N_SRC - 1));
endmodule

// File: rtl/irqd_checker.sv
// Property checker for irq_distributor, attached by bind below.
// Assumes: same N_SRC as the bound instance.
module irqd_checker
    import irqd_pkg::*;
#(
    parameter int N_SRC = 16,
    parameter int IDX_W = 4,
    parameter int ID_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic              ack_req,
    input logic [ID_W-1:0]   ack_id,
    input logic              eoi_valid,
    input logic [ID_W-1:0]   eoi_id,
    input prio_t             cpu_mask,
    input logic [N_SRC-1:0]  src_enable,
    input logic [N_SRC-1:0]  pend,
    input logic [N_SRC-1:0]  act,
    input prio_t [N_SRC-1:0] src_prio,
    input prio_t             sel_prio,
    input logic              run_found,
    input logic [IDX_W-1:0]  run_idx
);
    logic [IDX_W-1:0] ack_low, eoi_low;
    logic             eoi_in_range, eoi_same_as_ack;

    assign ack_low         = ack_id[IDX_W-1:0];
    assign eoi_low         = eoi_id[IDX_W-1:0];
    assign eoi_in_range    = (eoi_id <= ID_W'(N_SRC - 1));
    assign eoi_same_as_ack = ack_req && irq && (ack_id == eoi_id);

    // R1 / R5: a zero threshold blocks every source.
    a_r1_zero_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_mask == '0) |-> !irq);

    // R7: claiming with no request gives the all-ones code.
    a_r7_spurious_code: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !irq) |-> (ack_id == '1));

    // R4: an issued source is waiting and enabled.
    a_r4_issued_is_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend[ack_low] && src_enable[ack_low]));

    // R9: a source in service is never offered again.
    a_r9_no_reselect: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !act[ack_low]);

    // R9: nesting needs strictly better urgency than the running handler.
    a_r9_preempt_strict: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && run_found) |-> (sel_prio < src_prio[run_idx]));

    // R6: a claimed source is in service on the next cycle.
    a_r6_claim_activates: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && irq) |=> act[$past(ack_low)]);

    // R8: a valid release clears service on the next cycle.
    a_r8_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && eoi_in_range && !eoi_same_as_ack) |=> !act[$past(eoi_low)]);

    // R3: without a claim, no waiting flag drops.
    a_r3_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_req && irq) |=> ((pend & $past(pend)) == $past(pend)));
endmodule

bind irq_distributor irqd_checker #(.N_SRC(N_SRC), .IDX_W(IDX_W), .ID_W(ID_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq        (irq),
    .ack_req    (ack_req),
    .ack_id     (ack_id),
    .eoi_valid  (eoi_valid),
    .eoi_id     (eoi_id),
    .cpu_mask   (cpu_mask),
    .src_enable (src_enable),
    .pend       (pend),
    .act        (act),
    .src_prio   (src_prio),
    .sel_prio   (sel_prio),
    .run_found  (run_found),
    .run_idx    (run_idx)
);

// File: tb/irq_distributor_bench.sv
`timescale 1ns/1ps
module irq_distributor_bench;
    localparam int N      = 16;
    localparam int ID_W   = $clog2(N + 1);
    localparam int ADDR_W = $clog2(N + 2);
    localparam int DATA_W = 16;
    localparam int SPUR   = (1 << ID_W) - 1;
    localparam int HALF   = 2;   // 250 MHz

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      irq_lines = '0;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [DATA_W-1:0] cfg_wdata = '0;
    logic [DATA_W-1:0] cfg_rdata;
    logic              ack_req = 1'b0;
    logic [ID_W-1:0]   ack_id;
    logic              eoi_valid = 1'b0;
    logic [ID_W-1:0]   eoi_id = '0;
    logic              irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #HALF clk = ~clk;

    irq_distributor #(.N_SRC(N)) u_irq_distributor (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ack_req(ack_req), .ack_id(ack_id), .eoi_valid(eoi_valid), .eoi_id(eoi_id), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    bit [N-1:0] m_en, m_pend, m_act;
    int         m_prio [N];
    int         m_mask;

    function automatic void model_sel(output int best, output bit ok);
        int run = 256;
        int bp = 256;
        best = -1;
        for (int i = 0; i < N; i++) if (m_act[i] && m_prio[i] < run) run = m_prio[i];
        for (int i = 0; i < N; i++)
            if (m_pend[i] && m_en[i] && !m_act[i] && m_prio[i] < bp) begin
                bp = m_prio[i];
                best = i;
            end
        ok = (best >= 0) && (bp < ((m_mask < run) ? m_mask : run));
    endfunction

    function automatic int model_rd(input int a);
        if (a == 0) return m_mask;
        if (a == 1) return int'(m_en);
        if (a >= 2 && a < N + 2) return m_prio[a-2];
        return 0;
    endfunction

    // Model state update at each rising edge from the inputs in force.
    always @(posedge clk) begin : m_upd
        int b;
        bit q;
        bit [N-1:0] np, na;
        if (!rst_n) begin
            m_en = '0; m_pend = '0; m_act = '0; m_mask = 0;
            for (int i = 0; i < N; i++) m_prio[i] = 0;
        end else begin
            model_sel(b, q);
            np = m_pend;
            na = m_act;
            if (ack_req && q) begin na[b] = 1'b1; np[b] = 1'b0; end
            if (eoi_valid && int'(eoi_id) < N && m_act[eoi_id[3:0]]) na[eoi_id[3:0]] = 1'b0;
            np |= irq_lines;
            if (cfg_we) begin
                if (cfg_addr == 0) m_mask = int'(cfg_wdata[7:0]);
                else if (cfg_addr == 1) m_en = cfg_wdata[N-1:0];
                else if (int'(cfg_addr) < N + 2) m_prio[int'(cfg_addr) - 2] = int'(cfg_wdata[7:0]);
            end
            m_pend = np;
            m_act = na;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // Every-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin : cmp
        int b;
        bit q;
        if (rst_n && !done) begin
            model_sel(b, q);
            chk("R5 irq vs model", int'(irq), int'(q));
            if (q) chk("R4 ack_id vs model", int'(ack_id), b);
            else   chk("R7 ack_id vs model", int'(ack_id), SPUR);
            chk("R2 cfg_rdata vs model", int'(cfg_rdata), model_rd(int'(cfg_addr)));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic wr(input int a, input int d);
        cfg_we = 1'b1; cfg_addr = ADDR_W'(a); cfg_wdata = DATA_W'(d);
        cyc();
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int a, input int exp);
        cfg_addr = ADDR_W'(a);
        @(negedge clk);
        chk(tag, int'(cfg_rdata), exp);
        cyc();
    endtask

    task automatic pulse(input int bits);
        irq_lines = N'(bits);
        cyc();
        irq_lines = '0;
    endtask

    task automatic peek_irq(input string tag, input int exp);
        @(negedge clk);
        chk(tag, int'(irq), exp);
        cyc();
    endtask

    task automatic claim(input string tag, input int exp);
        ack_req = 1'b1;
        @(negedge clk);
        chk(tag, int'(ack_id), exp);
        cyc();
        ack_req = 1'b0;
    endtask

    task automatic release_id(input int id);
        eoi_valid = 1'b1; eoi_id = ID_W'(id);
        cyc();
        eoi_valid = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(2 * HALF * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1 irq after reset", int'(irq), 0);
        chk("R1 ack_id after reset", int'(ack_id), SPUR);
        cyc();
        rd_chk("R1 mask after reset", 0, 0);
        rd_chk("R1 enable after reset", 1, 0);
        rd_chk("R1 prio0 after reset", 2, 0);

        // R2: register map, truncation, unmapped address
        wr(0, 'hF0);
        rd_chk("R2 mask readback", 0, 'hF0);
        wr(2 + 3, 'h1234);
        rd_chk("R2 prio3 keeps 8 bits", 2 + 3, 'h34);
        wr(25, 'hFFFF);
        rd_chk("R2 unmapped reads zero", 25, 0);
        rd_chk("R2 unmapped write ignored", 1, 0);

        // R3: waiting latched while disabled, issued once enabled
        pulse(1 << 3);
        peek_irq("R3 disabled source silent", 0);
        wr(1, 1 << 3);
        peek_irq("R3 latched source issues", 1);
        claim("R6 claim returns source 3", 3);
        release_id(3);
        peek_irq("R6 nothing left", 0);

        // R4 / R9 / R10: value then ID ordering, held sources issued later
        wr(2 + 5, 'h10);
        wr(2 + 2, 'h10);
        wr(2 + 9, 'h08);
        wr(1, (1 << 2) | (1 << 5) | (1 << 9));
        pulse((1 << 2) | (1 << 5) | (1 << 9));
        claim("R4 lowest value wins", 9);
        peek_irq("R9 less urgent cannot nest", 0);
        release_id(9);
        claim("R4 tie goes to lower ID", 2);
        release_id(2);
        claim("R10 held source issued later", 5);
        release_id(5);
        peek_irq("R10 queue drained", 0);

        // R5 / R7: strict threshold and spurious claim
        wr(0, 'h10);
        pulse(1 << 5);
        peek_irq("R5 equal to threshold blocked", 0);
        claim("R7 spurious code", SPUR);
        wr(0, 'h11);
        peek_irq("R7 spurious claim left source waiting", 1);
        claim("R5 issued above threshold", 5);

        // R9: nesting by a strictly more urgent source only
        pulse(1 << 9);
        peek_irq("R9 more urgent nests", 1);
        claim("R9 nested claim", 9);
        pulse(1 << 2);
        peek_irq("R9 equal to running blocked", 0);
        release_id(9);
        peek_irq("R9 still blocked by running 5", 0);
        release_id(5);
        peek_irq("R9 issued after release", 1);
        claim("R9 claim after release", 2);
        release_id(2);

        // R8: out-of-range release must not alias onto source 5
        pulse(1 << 5);
        claim("R8 claim 5", 5);
        release_id(16 + 5);
        pulse(1 << 2);
        peek_irq("R8 out-of-range release ignored", 0);
        release_id(7);
        peek_irq("R8 idle release ignored", 0);
        release_id(5);
        peek_irq("R8 valid release", 1);
        claim("R8 claim 2", 2);
        release_id(2);

        // R6: line held through its own claim re-latches
        irq_lines = N'(1 << 5);
        cyc();
        claim("R6 claim held line", 5);
        irq_lines = '0;
        peek_irq("R6 in service, not reissued", 0);
        release_id(5);
        peek_irq("R6 relatched source reissued", 1);
        claim("R6 reissued claim", 5);
        release_id(5);
        peek_irq("R6 done", 0);

        // Random phase against the model
        wr(0, 'hFF);
        wr(1, 'hFFFF);
        for (int t = 0; t < 3000; t++) begin
            logic [N-1:0] lv;
            for (int i = 0; i < N; i++) lv[i] = ($urandom % 12) == 0;
            irq_lines = lv;
            ack_req = ($urandom % 3) == 0;
            eoi_valid = ($urandom % 4) == 0;
            eoi_id = ID_W'($urandom % 32);
            if ($urandom % 2 == 0)
                for (int i = 0; i < N; i++) if (m_act[i] && ($urandom % 2 == 0)) eoi_id = ID_W'(i);
            cfg_we = ($urandom % 8) == 0;
            case ($urandom % 4)
                0: begin cfg_addr = 0; cfg_wdata = DATA_W'(($urandom % 4) * 'h30 + 'h10); end
                1: begin cfg_addr = 1; cfg_wdata = DATA_W'($urandom); end
                default: begin
                    cfg_addr = ADDR_W'($urandom % 32);
                    cfg_wdata = DATA_W'(($urandom % 4) << 4);
                end
            endcase
            cyc();
        end
        irq_lines = '0; ack_req = 1'b0; eoi_valid = 1'b0; cfg_we = 1'b0;
        cyc();
        finish_run();
    end
endmodule